// File: doc/BRIEF.md
# Shared-Line Bus Ownership Handshake

This block moves ownership of a shared system bus between a host bus master and one secondary master. The two sides talk over a single active-low request/grant wire. The requester pulls the wire low for one clock to ask for the bus. The host finishes any bus cycle it has under way, then pulls the wire low for one clock to grant the bus, and holds off its own bus activity. The requester then performs its memory transfers and pulls the wire low for one more clock to hand the bus back. After that the host resumes.

The wire is modelled as open-drain. Each side has its own drive-enable output (`host_oe`, `req_oe`). The resolved wire level comes back in on `line_n`, and the surrounding logic forms it as the wired-AND of every driver with a pull-up. The requester takes work as a job of `job_len` memory transfers over a valid/ready pair: a job is accepted in any cycle where `job_valid` and `job_ready` are both high, and `job_ready` stays low until the job's release pulse has been sent.

The individual transfers leave the block as `mem_valid` and come back as `mem_ready`. `mem_valid` stays high and unchanged until `mem_ready` completes it, so the memory side may apply back-pressure for any number of cycles. The host exposes `hold_ack`, which tristates its bus drivers while the secondary master owns the bus.

Top module: `rg_handshake`

## Requirements
- R1: After reset both drive enables, `hold_ack`, `own_bus` and `mem_valid` are low and `job_ready` is high.
- R2: A job accepted in cycle A produces a request pulse (`req_oe` high) in cycle A+1 only, and `job_ready` is low from cycle A+1 onward.
- R3: If `bus_busy` is low, the grant pulse (`host_oe` high for exactly one cycle) comes two cycles after the request pulse.
- R4: While `bus_busy` is high after a request has been seen, no grant is given. The grant comes in the cycle after the first cycle in which `bus_busy` is sampled low.
- R5: `hold_ack` is high from the grant cycle through the release-pulse cycle inclusive, and low in the cycle after the release pulse.
- R6: `own_bus` rises in the cycle after the grant. `mem_valid` is high only while `own_bus` is high and stays high until `mem_ready`. Exactly `job_len` transfers complete (`mem_valid` and `mem_ready` both high), and a `job_len` of 0 gives none.
- R7: The release pulse (`req_oe` high for one cycle) comes in the cycle after the first ownership cycle with no transfers left. `own_bus` is low from that cycle on, and `job_ready` returns high in the following cycle.
- R8: The host ignores a low pulse on the line sampled in the first cycle after the grant, treating it as a repeated request. `hold_ack` stays high until the real release.
- R9: `host_oe` and `req_oe` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_n | input | 1 | Resolved level of the shared request/grant wire |
| host_oe | output | 1 | Host pulls the wire low (grant pulse) |
| req_oe | output | 1 | Requester pulls the wire low (request or release pulse) |
| bus_busy | input | 1 | A host bus cycle is in progress |
| hold_ack | output | 1 | Host is in hold; its bus drivers are tristated |
| job_valid | input | 1 | A transfer job is offered |
| job_ready | output | 1 | Requester can accept a job |
| job_len | input | LEN_W | Number of transfers in the offered job |
| own_bus | output | 1 | Secondary master owns the bus |
| mem_valid | output | 1 | A memory transfer is being started |
| mem_ready | input | 1 | The memory transfer completes this cycle |

## Verification
Two events can coincide here: the host's bus cycle ending in the same cycle that the request pulse sits on the wire, and a stray low pulse arriving in the same cycle the requester performs its first transfer under hold. The first is provoked by dropping `bus_busy` in the request cycle; the grant must then appear exactly two cycles after the request, as if the bus had been idle. The second is provoked by injecting a one-cycle low pulse on the wire in the first cycle of hold while transfers run; it is judged by `hold_ack` staying high and the release and end of hold landing on the cycles predicted from `job_len`.

// File: rtl/rg_pkg.sv
package rg_pkg;

  typedef enum logic [2:0] {
    HS_IDLE   = 3'd0,
    HS_FINISH = 3'd1,
    HS_GRANT  = 3'd2,
    HS_HOLD   = 3'd3,
    HS_RESUME = 3'd4
  } host_st_t;

  typedef enum logic [2:0] {
    QS_IDLE = 3'd0,
    QS_ASK  = 3'd1,
    QS_WAIT = 3'd2,
    QS_OWN  = 3'd3,
    QS_GIVE = 3'd4
  } reqr_st_t;

endpackage

// File: rtl/rg_pulse_sense.sv
// Detects a falling edge of the shared wire caused by the other side:
// the wire is treated as low only when this side is not driving it.
module rg_pulse_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  input  logic own_oe,
  output logic pulse_seen
);
  logic low_now;
  logic low_prev;

  assign low_now = !line_n && !own_oe;

  always_ff @(posedge clk) begin
    if (!rst_n) low_prev <= 1'b0;
    else        low_prev <= low_now;
  end

  assign pulse_seen = low_now && !low_prev;
endmodule

// File: rtl/rg_host_side.sv
module rg_host_side
  import rg_pkg::*;
#(
  parameter int HOLD_GUARD = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_seen,
  input  logic bus_busy,
  output logic host_oe,
  output logic hold_ack
);
  localparam int GW = (HOLD_GUARD < 1) ? 1 : $clog2(HOLD_GUARD + 1);
  localparam logic [GW-1:0] GUARD_V = GW'(HOLD_GUARD);

  host_st_t st, st_nxt;
  logic [GW-1:0] guard_q;
  logic          release_ok;

  assign release_ok = pulse_seen && (guard_q >= GUARD_V);

  always_comb begin
    st_nxt = st;
    case (st)
      HS_IDLE:   if (pulse_seen) st_nxt = HS_FINISH;
      HS_FINISH: if (!bus_busy)  st_nxt = HS_GRANT;
      HS_GRANT:                  st_nxt = HS_HOLD;
      HS_HOLD:   if (release_ok) st_nxt = HS_RESUME;
      HS_RESUME:                 st_nxt = HS_IDLE;
      default:                   st_nxt = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= HS_IDLE;
      guard_q <= '0;
    end else begin
      st <= st_nxt;
      if (st == HS_GRANT)
        guard_q <= '0;
      else if (st == HS_HOLD && guard_q < GUARD_V)
        guard_q <= guard_q + 1'b1;
    end
  end

  assign host_oe  = (st == HS_GRANT);
  assign hold_ack = (st == HS_GRANT) || (st == HS_HOLD);
endmodule

// File: rtl/rg_req_side.sv
module rg_req_side
  import rg_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_seen,
  input  logic             job_valid,
  output logic             job_ready,
  input  logic [LEN_W-1:0] job_len,
  output logic             req_oe,
  output logic             own_bus,
  output logic             mem_valid,
  input  logic             mem_ready
);
  reqr_st_t st, st_nxt;
  logic [LEN_W-1:0] left_q;
  logic             none_left;

  assign none_left = (left_q == '0);

  always_comb begin
    st_nxt = st;
    case (st)
      QS_IDLE: if (job_valid)  st_nxt = QS_ASK;
      QS_ASK:                  st_nxt = QS_WAIT;
      QS_WAIT: if (pulse_seen) st_nxt = QS_OWN;
      QS_OWN:  if (none_left)  st_nxt = QS_GIVE;
      QS_GIVE:                 st_nxt = QS_IDLE;
      default:                 st_nxt = QS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= QS_IDLE;
      left_q <= '0;
    end else begin
      st <= st_nxt;
      if (st == QS_IDLE && job_valid)
        left_q <= job_len;
      else if (mem_valid && mem_ready)
        left_q <= left_q - 1'b1;
    end
  end

  assign job_ready = (st == QS_IDLE);
  assign req_oe    = (st == QS_ASK) || (st == QS_GIVE);
  assign own_bus   = (st == QS_OWN);
  assign mem_valid = (st == QS_OWN) && !none_left;
endmodule

// File: rtl/rg_handshake.sv
module rg_handshake #(
  parameter int LEN_W      = 4,
  parameter int HOLD_GUARD = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_n,
  output logic             host_oe,
  output logic             req_oe,
  input  logic             bus_busy,
  output logic             hold_ack,
  input  logic             job_valid,
  output logic             job_ready,
  input  logic [LEN_W-1:0] job_len,
  output logic             own_bus,
  output logic             mem_valid,
  input  logic             mem_ready
);
  logic host_heard;
  logic req_heard;

  rg_pulse_sense host_sense_i (
    .clk(clk), .rst_n(rst_n), .line_n(line_n),
    .own_oe(host_oe), .pulse_seen(host_heard)
  );

  rg_pulse_sense req_sense_i (
    .clk(clk), .rst_n(rst_n), .line_n(line_n),
    .own_oe(req_oe), .pulse_seen(req_heard)
  );

  rg_host_side #(.HOLD_GUARD(HOLD_GUARD)) host_i (
    .clk(clk), .rst_n(rst_n), .pulse_seen(host_heard),
    .bus_busy(bus_busy), .host_oe(host_oe), .hold_ack(hold_ack)
  );

  rg_req_side #(.LEN_W(LEN_W)) reqr_i (
    .clk(clk), .rst_n(rst_n), .pulse_seen(req_heard),
    .job_valid(job_valid), .job_ready(job_ready), .job_len(job_len),
    .req_oe(req_oe), .own_bus(own_bus),
    .mem_valid(mem_valid), .mem_ready(mem_ready)
  );
endmodule

// File: rtl/rg_handshake_chk.sv
module rg_handshake_chk (
  input logic clk,
  input logic rst_n,
  input logic host_oe,
  input logic req_oe,
  input logic bus_busy,
  input logic hold_ack,
  input logic job_valid,
  input logic job_ready,
  input logic own_bus,
  input logic mem_valid,
  input logic mem_ready
);
  // R9
  excl_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_oe && req_oe));

  // R2
  req_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_oe |=> !req_oe);

  // R2
  job_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (job_valid && job_ready) |=> (req_oe && !job_ready));

  // R3
  grant_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_oe |=> !host_oe);

  // R4
  grant_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_oe |-> $past(!bus_busy));

  // R5
  grant_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_oe |-> hold_ack);

  // R6
  own_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_bus |-> hold_ack);

  // R6
  mem_in_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> own_bus);

  // R6
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid);

  // R8
  guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_oe) |-> hold_ack);
endmodule

bind rg_handshake rg_handshake_chk chk_i (
  .clk(clk), .rst_n(rst_n), .host_oe(host_oe), .req_oe(req_oe),
  .bus_busy(bus_busy), .hold_ack(hold_ack), .job_valid(job_valid),
  .job_ready(job_ready), .own_bus(own_bus), .mem_valid(mem_valid),
  .mem_ready(mem_ready)
);

// File: tb/rg_handshake_tb_top.sv
module rg_handshake_tb_top;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_oe, req_oe, hold_ack, job_ready, own_bus, mem_valid;
  logic bus_busy = 1'b0;
  logic job_valid = 1'b0;
  logic [LW-1:0] job_len = '0;
  logic mem_ready = 1'b1;
  logic inj = 1'b0;
  logic line_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // open-drain wire with pull-up
  assign line_n = !(host_oe || req_oe || inj);

  always #10 clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  rg_handshake #(.LEN_W(LW), .HOLD_GUARD(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_n(line_n), .host_oe(host_oe),
    .req_oe(req_oe), .bus_busy(bus_busy), .hold_ack(hold_ack),
    .job_valid(job_valid), .job_ready(job_ready), .job_len(job_len),
    .own_bus(own_bus), .mem_valid(mem_valid), .mem_ready(mem_ready)
  );

  // event log, sampled mid-cycle
  int req_cyc, rel_cyc, gnt_cyc, gnt_n, hold_first, hold_last;
  int own_first, own_last, xfers, ready_back, dual;

  task automatic clear_log();
    req_cyc = -1; rel_cyc = -1; gnt_cyc = -1; gnt_n = 0;
    hold_first = -1; hold_last = -1; own_first = -1; own_last = -1;
    xfers = 0; ready_back = -1; dual = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (req_oe) begin
        if (req_cyc < 0) req_cyc = cyc; else rel_cyc = cyc;
      end
      if (host_oe) begin gnt_cyc = cyc; gnt_n++; end
      if (hold_ack) begin
        if (hold_first < 0) hold_first = cyc;
        hold_last = cyc;
      end
      if (own_bus) begin
        if (own_first < 0) own_first = cyc;
        own_last = cyc;
      end
      if (mem_valid && mem_ready) xfers++;
      if (host_oe && req_oe) dual++;
      if (rel_cyc >= 0 && job_ready && ready_back < 0) ready_back = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // offer a job at a negedge; returns the acceptance cycle
  task automatic offer(input int len, output int a);
    @(negedge clk);
    clear_log();
    job_len = LW'(len);
    job_valid = 1'b1;
    a = cyc;
    @(negedge clk);
    job_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!host_oe && !req_oe, "R1 drivers", {host_oe, req_oe}, 0);
    chk(!hold_ack && !own_bus && !mem_valid, "R1 hold/own", hold_ack, 0);
    chk(job_ready, "R1 job_ready", job_ready, 1);
  endtask

  task automatic t_basic();
    int a;
    offer(3, a);
    chk(!job_ready, "R2 ready low", job_ready, 0);
    settle();
    chk(req_cyc == a + 1, "R2 request cycle", req_cyc, a + 1);
    chk(gnt_cyc == a + 3 && gnt_n == 1, "R3 grant cycle", gnt_cyc, a + 3);
    chk(own_first == a + 4, "R6 own start", own_first, a + 4);
    chk(xfers == 3, "R6 transfers", xfers, 3);
    chk(rel_cyc == a + 8, "R7 release cycle", rel_cyc, a + 8);
    chk(own_last == a + 7, "R7 own end", own_last, a + 7);
    chk(hold_first == a + 3, "R5 hold start", hold_first, a + 3);
    chk(hold_last == a + 8, "R5 hold end", hold_last, a + 8);
    chk(ready_back == a + 9, "R7 ready back", ready_back, a + 9);
    chk(dual == 0, "R9 exclusive", dual, 0);
  endtask

  task automatic t_busy_defer();
    int a;
    bus_busy = 1'b1;
    offer(1, a);
    while (cyc < a + 5) @(negedge clk);
    chk(gnt_n == 0 && !hold_ack, "R4 no grant while busy", gnt_n, 0);
    bus_busy = 1'b0;
    settle();
    chk(gnt_cyc == a + 6, "R4 deferred grant", gnt_cyc, a + 6);
    chk(xfers == 1, "R6 transfers deferred", xfers, 1);
    chk(hold_last == rel_cyc, "R5 hold to release", hold_last, rel_cyc);
  endtask

  task automatic t_busy_collide();
    int a;
    bus_busy = 1'b1;
    offer(2, a);               // now in cycle a+1, the request cycle
    bus_busy = 1'b0;
    settle();
    chk(req_cyc == a + 1, "R2 request with busy", req_cyc, a + 1);
    chk(gnt_cyc == a + 3, "R4 busy ends with request", gnt_cyc, a + 3);
    chk(dual == 0, "R9 exclusive collide", dual, 0);
  endtask

  task automatic t_backpressure();
    int a;
    mem_ready = 1'b0;
    offer(2, a);
    while (cyc < a + 7) @(negedge clk);
    chk(mem_valid && own_bus, "R6 valid held", mem_valid, 1);
    chk(xfers == 0, "R6 no early transfer", xfers, 0);
    mem_ready = 1'b1;
    settle();
    chk(xfers == 2, "R6 transfers back-pressure", xfers, 2);
    chk(rel_cyc == a + 10, "R7 release after stall", rel_cyc, a + 10);
  endtask

  task automatic t_stray_pulse();
    int a;
    offer(3, a);
    while (cyc < a + 4) @(negedge clk);
    inj = 1'b1;                // line low sampled at end of a+4 only
    @(negedge clk);
    inj = 1'b0;
    chk(hold_ack, "R8 hold kept", hold_ack, 1);
    settle();
    chk(hold_last == a + 8, "R8 hold end", hold_last, a + 8);
    chk(rel_cyc == a + 8, "R8 release", rel_cyc, a + 8);
    chk(xfers == 3, "R8 transfers", xfers, 3);
  endtask

  task automatic t_zero_len();
    int a;
    offer(0, a);
    settle();
    chk(xfers == 0, "R6 zero length", xfers, 0);
    chk(own_first == a + 4 && own_last == a + 4, "R7 zero own", own_last, a + 4);
    chk(rel_cyc == a + 5, "R7 zero release", rel_cyc, a + 5);
    chk(!hold_ack, "R5 hold dropped", hold_ack, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_busy_defer();
    t_busy_collide();
    t_backpressure();
    t_stray_pulse();
    t_zero_len();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule